// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block makes the bit clock and the left/right frame clocks of a serial audio port. In master mode it divides them down from the master clock with three programmable 8-bit dividers: one for the bit clock and one frame divider each for the transmit and receive directions. In slave mode it takes the bit clock and frame clock from outside the chip. It resynchronises them into the master clock domain and passes them on.

Next to the clock outputs, the block produces single-cycle strobes in the master clock domain. A shift strobe marks the start of each bit, where the bit clock falls. A sample strobe marks the middle of each bit, where the bit clock rises. A frame strobe per direction marks the first bit of a frame. A serializer uses these strobes instead of the clocks themselves. A polarity bit inverts the bit clock at the pin. The strobes always refer to the clock before that inversion.

Each divider field holds the wanted ratio minus one. Divider changes are held in shadow registers and take effect only at a frame boundary, so no shortened clock phases appear.

Top module: `aud_clkgen`

## Requirements
- R1: While `rst` is high, every output is 0. In master mode, the first cycle after `rst` falls shows `shift_stb`, `tx_frame_stb` and `rx_frame_stb` at 1. All outputs are registered and change one master clock after the internal state that drives them.
- R2: In master mode, a bit-divider field value D gives a bit period of N = D+1 master clocks. The unregistered (raw) bit clock is low for the first N - floor(N/2) cycles of the period and high for the rest. D = 0 keeps the raw bit clock low and gives a shift strobe on every cycle.
- R3: `shift_stb` is 1 for one cycle where the raw bit clock enters its low phase. `sample_stb` is 1 for one cycle where it enters its high phase. The two strobes are never 1 in the same cycle.
- R4: When `bclk_inv` is 1, `bclk_o` is the inverse of the raw bit clock. The strobes and the frame clocks are unaffected.
- R5: In master mode, a frame-divider field value G gives a frame of F = G+1 bit periods. Its frame clock is 0 (left) for the first F - floor(F/2) bits and 1 for the rest. It changes only together with a shift strobe.
- R6: The transmit and receive frame clocks run from separate divider fields (`tx_frame_div`, `rx_frame_div`) and count independently on the same bit clock.
- R7: A frame strobe is 1 for one cycle on the first bit of each frame of its direction, in the same cycle as the shift strobe.
- R8: A new bit-divider value or transmit frame-divider value is loaded only at the end of a transmit frame. A new receive frame-divider value is loaded only at the end of a receive frame.
- R9: With `slave_sel` = 1, `ext_bclk` and `ext_lrck` each pass through a two-flop synchronizer. `bclk_o` then shows the synchronized `ext_bclk`, and both frame clock outputs show the synchronized `ext_lrck`. A pin change is seen at the outputs three master clocks later.
- R10: In slave mode the strobes come from edges of the synchronized `ext_bclk` XOR `bclk_inv`. A falling edge gives `shift_stb` and a rising edge gives `sample_stb`. A falling edge of the synchronized `ext_lrck` gives both frame strobes.
- R11: While `slave_sel` is 1, the master counters are held at the start of a frame and the shadow registers follow the divider fields. After a return to master mode, a new frame starts at once with the current field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_sel | input | 1 | 0: generate the clocks, 1: accept external clocks |
| bclk_inv | input | 1 | Invert the bit clock at the pin |
| bit_div | input | 8 | Master clocks per bit, minus one |
| rx_frame_div | input | 8 | Bits per receive frame, minus one |
| tx_frame_div | input | 8 | Bits per transmit frame, minus one |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrck | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock |
| tx_lrck_o | output | 1 | Transmit frame clock, 0 = left |
| rx_lrck_o | output | 1 | Receive frame clock, 0 = left |
| shift_stb | output | 1 | Start of a bit |
| sample_stb | output | 1 | Middle of a bit |
| tx_frame_stb | output | 1 | First bit of a transmit frame |
| rx_frame_stb | output | 1 | First bit of a receive frame |

## Verification
The bench goes after the divide-by-one and odd bit ratios. A design that got these wrong would make a sample strobe with no high phase, or an uneven split off by one cycle. It changes dividers in the middle of a frame, where a design that loads at once would emit a runt half-frame. It runs the transmit and receive frame lengths apart, which catches a shared frame counter. In slave mode it flips the polarity while running, which exposes strobes taken from the pin level instead of the corrected clock. It also switches back to master mode, where counters left running during slave mode would start mid-frame.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
  localparam int DIV_W_DEF = 8;

  typedef enum logic {
    MODE_MASTER = 1'b0,
    MODE_SLAVE  = 1'b1
  } clk_mode_e;

  typedef struct packed {
    logic bclk;
    logic tx_lr;
    logic rx_lr;
    logic shift;
    logic sample;
    logic tx_frame;
    logic rx_frame;
  } clk_evt_t;
endpackage

// File: rtl/aud_bit_div.sv
module aud_bit_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             bit_end,
  output logic             bit_start,
  output logic             raw_bclk,
  output logic             mid_bit
);
  localparam int RW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] shadow_q;
  logic [RW-1:0]    ratio;
  logic [RW-1:0]    low_len;

  // Period is shadow+1; the low phase takes the larger half.
  assign ratio   = {1'b0, shadow_q} + RW'(1);
  assign low_len = ratio - (ratio >> 1);

  assign bit_end   = (cnt_q == shadow_q);
  assign bit_start = (cnt_q == '0);
  assign raw_bclk  = ({1'b0, cnt_q} >= low_len);
  assign mid_bit   = (shadow_q != '0) && ({1'b0, cnt_q} == low_len);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q    <= '0;
      shadow_q <= div_in;
    end else if (bit_end) begin
      cnt_q <= '0;
      if (load) shadow_q <= div_in;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/aud_frame_div.sv
module aud_frame_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             bit_end,
  input  logic [DIV_W-1:0] div_in,
  output logic             frame_wrap,
  output logic             first_bit,
  output logic             lr
);
  localparam int RW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] shadow_q;
  logic [RW-1:0]    len;
  logic [RW-1:0]    left_len;

  assign len        = {1'b0, shadow_q} + RW'(1);
  assign left_len   = len - (len >> 1);
  assign frame_wrap = bit_end && (cnt_q == shadow_q);
  assign first_bit  = (cnt_q == '0);
  assign lr         = ({1'b0, cnt_q} >= left_len);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q    <= '0;
      shadow_q <= div_in;
    end else if (bit_end) begin
      if (cnt_q == shadow_q) begin
        cnt_q    <= '0;
        shadow_q <= div_in;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/aud_sync_edge.sv
module aud_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // STAGES synchronizing flops plus one history flop for edge detection.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clk_pkg::*;
#(
  parameter int DIV_W       = DIV_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_sel,
  input  logic             bclk_inv,
  input  logic [DIV_W-1:0] bit_div,
  input  logic [DIV_W-1:0] rx_frame_div,
  input  logic [DIV_W-1:0] tx_frame_div,
  input  logic             ext_bclk,
  input  logic             ext_lrck,
  output logic             bclk_o,
  output logic             tx_lrck_o,
  output logic             rx_lrck_o,
  output logic             shift_stb,
  output logic             sample_stb,
  output logic             tx_frame_stb,
  output logic             rx_frame_stb
);
  clk_mode_e mode;
  assign mode = clk_mode_e'(slave_sel);

  logic hold;
  assign hold = (mode == MODE_SLAVE);

  // Master path.
  logic bit_end, bit_start, raw_bclk, mid_bit;
  logic tx_wrap, tx_first, tx_lr;
  logic rx_wrap, rx_first, rx_lr;

  aud_bit_div #(.DIV_W(DIV_W)) u_bit (
    .clk(clk), .rst(rst), .hold(hold), .load(tx_wrap), .div_in(bit_div),
    .bit_end(bit_end), .bit_start(bit_start), .raw_bclk(raw_bclk), .mid_bit(mid_bit)
  );

  aud_frame_div #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .hold(hold), .bit_end(bit_end), .div_in(tx_frame_div),
    .frame_wrap(tx_wrap), .first_bit(tx_first), .lr(tx_lr)
  );

  aud_frame_div #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .hold(hold), .bit_end(bit_end), .div_in(rx_frame_div),
    .frame_wrap(rx_wrap), .first_bit(rx_first), .lr(rx_lr)
  );

  // Slave path.
  logic sb_lvl, sb_rise, sb_fall;
  logic sl_lvl, sl_rise, sl_fall;

  aud_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .din(ext_bclk), .lvl(sb_lvl), .rise(sb_rise), .fall(sb_fall)
  );

  aud_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_l (
    .clk(clk), .rst(rst), .din(ext_lrck), .lvl(sl_lvl), .rise(sl_rise), .fall(sl_fall)
  );

  clk_evt_t m_evt, s_evt, nxt, out_q;

  always_comb begin
    m_evt.bclk     = raw_bclk ^ bclk_inv;
    m_evt.tx_lr    = tx_lr;
    m_evt.rx_lr    = rx_lr;
    m_evt.shift    = bit_start;
    m_evt.sample   = mid_bit;
    m_evt.tx_frame = bit_start & tx_first;
    m_evt.rx_frame = bit_start & rx_first;

    // The pin carries raw^inv, so the raw edges swap with polarity.
    s_evt.bclk     = sb_lvl;
    s_evt.tx_lr    = sl_lvl;
    s_evt.rx_lr    = sl_lvl;
    s_evt.shift    = bclk_inv ? sb_rise : sb_fall;
    s_evt.sample   = bclk_inv ? sb_fall : sb_rise;
    s_evt.tx_frame = sl_fall;
    s_evt.rx_frame = sl_fall;

    nxt = (mode == MODE_SLAVE) ? s_evt : m_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= nxt;
  end

  assign bclk_o       = out_q.bclk;
  assign tx_lrck_o    = out_q.tx_lr;
  assign rx_lrck_o    = out_q.rx_lr;
  assign shift_stb    = out_q.shift;
  assign sample_stb   = out_q.sample;
  assign tx_frame_stb = out_q.tx_frame;
  assign rx_frame_stb = out_q.rx_frame;

  logic unused_ok;
  assign unused_ok = &{1'b0, rx_wrap, sl_rise};
endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic slave_sel,
  input logic bclk_inv,
  input logic bclk_o,
  input logic tx_lrck_o,
  input logic rx_lrck_o,
  input logic shift_stb,
  input logic sample_stb,
  input logic tx_frame_stb,
  input logic rx_frame_stb
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(shift_stb && sample_stb));

  assert_shift_low_R4: assert property (@(posedge clk) disable iff (rst)
    shift_stb |-> (bclk_o == $past(bclk_inv)));

  assert_sample_high_R4: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (bclk_o == !$past(bclk_inv)));

  assert_tx_left_R7: assert property (@(posedge clk) disable iff (rst)
    tx_frame_stb |-> !tx_lrck_o);

  assert_rx_left_R7: assert property (@(posedge clk) disable iff (rst)
    rx_frame_stb |-> !rx_lrck_o);

  assert_frame_on_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(slave_sel) && (tx_frame_stb || rx_frame_stb)) |-> shift_stb);

  assert_lr_moves_on_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(slave_sel) && !$past(slave_sel, 2) && (tx_lrck_o != $past(tx_lrck_o)))
      |-> shift_stb);
endmodule

bind aud_clkgen aud_clkgen_chk u_chk (
  .clk(clk), .rst(rst), .slave_sel(slave_sel), .bclk_inv(bclk_inv),
  .bclk_o(bclk_o), .tx_lrck_o(tx_lrck_o), .rx_lrck_o(rx_lrck_o),
  .shift_stb(shift_stb), .sample_stb(sample_stb),
  .tx_frame_stb(tx_frame_stb), .rx_frame_stb(rx_frame_stb)
);

// File: tb/tb_aud_clkgen.sv
module tb_aud_clkgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_sel = 1'b0, bclk_inv = 1'b0;
  logic [7:0] bit_div = 8'd3, rx_frame_div = 8'd31, tx_frame_div = 8'd63;
  logic ext_bclk = 1'b0, ext_lrck = 1'b0;
  logic bclk_o, tx_lrck_o, rx_lrck_o, shift_stb, sample_stb, tx_frame_stb, rx_frame_stb;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  aud_clkgen dut (
    .clk(clk), .rst(rst), .slave_sel(slave_sel), .bclk_inv(bclk_inv),
    .bit_div(bit_div), .rx_frame_div(rx_frame_div), .tx_frame_div(tx_frame_div),
    .ext_bclk(ext_bclk), .ext_lrck(ext_lrck),
    .bclk_o(bclk_o), .tx_lrck_o(tx_lrck_o), .rx_lrck_o(rx_lrck_o),
    .shift_stb(shift_stb), .sample_stb(sample_stb),
    .tx_frame_stb(tx_frame_stb), .rx_frame_stb(rx_frame_stb)
  );

  // Behavioural reference model.
  int mb, mt, mr, nb, nt, nr;
  bit s1, s2, s3, l1, l2, l3;
  bit e_bclk, e_tl, e_rl, e_sh, e_sa, e_tf, e_rf;

  always @(posedge clk) begin
    int n, ft, fr;
    bit rp, rn;
    if (rst) begin
      mb = 0; mt = 0; mr = 0;
      nb = bit_div; nt = tx_frame_div; nr = rx_frame_div;
      s1 = 0; s2 = 0; s3 = 0; l1 = 0; l2 = 0; l3 = 0;
      {e_bclk, e_tl, e_rl, e_sh, e_sa, e_tf, e_rf} = '0;
    end else begin
      if (slave_sel) begin
        rp = s3 ^ bclk_inv; rn = s2 ^ bclk_inv;
        e_bclk = s2; e_tl = l2; e_rl = l2;
        e_sh = rp && !rn; e_sa = !rp && rn;
        e_tf = l3 && !l2; e_rf = e_tf;
      end else begin
        n = nb + 1; ft = nt + 1; fr = nr + 1;
        e_bclk = (mb >= n - n / 2) ^ bclk_inv;
        e_sh = (mb == 0);
        e_sa = (n >= 2) && (mb == n - n / 2);
        e_tl = (mt >= ft - ft / 2);
        e_rl = (mr >= fr - fr / 2);
        e_tf = e_sh && (mt == 0);
        e_rf = e_sh && (mr == 0);
      end
      s3 = s2; s2 = s1; s1 = ext_bclk;
      l3 = l2; l2 = l1; l1 = ext_lrck;
      if (slave_sel) begin
        mb = 0; mt = 0; mr = 0;
        nb = bit_div; nt = tx_frame_div; nr = rx_frame_div;
      end else if (mb == nb) begin
        mb = 0;
        if (mt == nt) begin mt = 0; nb = bit_div; nt = tx_frame_div; end
        else mt++;
        if (mr == nr) begin mr = 0; nr = rx_frame_div; end
        else mr++;
      end else begin
        mb++;
      end
    end
  end

  task automatic chk(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("bclk_o", bclk_o, e_bclk);
      chk("tx_lrck_o", tx_lrck_o, e_tl);
      chk("rx_lrck_o", rx_lrck_o, e_rl);
      chk("shift_stb", shift_stb, e_sh);
      chk("sample_stb", sample_stb, e_sa);
      chk("tx_frame_stb", tx_frame_stb, e_tf);
      chk("rx_frame_stb", rx_frame_stb, e_rf);
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive external clocks: bit half-period hp cycles, frame half = fh bits.
  task automatic drive_ext(int cycles, int hp, int fh);
    int bc = 0;
    int half = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      bc++;
      if (bc == hp) begin
        bc = 0;
        ext_bclk = ~ext_bclk;
        if (ext_bclk == 1'b0) begin
          half++;
          if (half == fh) begin half = 0; ext_lrck = ~ext_lrck; end
        end
      end
    end
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    cmp_on = 1'b1;
    cur_req = "R1";
    wait_cyc(2);
    @(negedge clk) rst = 1'b0;        // R1: first cycle after release
    cur_req = "R2";
    wait_cyc(1100);                    // R2 R5 R6 R7: ratios 4, 64 and 32
    cur_req = "R8";
    bit_div = 8'd0;                    // R8: held until the transmit frame ends
    wait_cyc(600);
    cur_req = "R2";
    bit_div = 8'd2; tx_frame_div = 8'd7; rx_frame_div = 8'd4;
    wait_cyc(500);                     // R2 odd ratio, R6 unequal frames
    cur_req = "R4";
    bclk_inv = 1'b1;
    wait_cyc(200);
    cur_req = "R8";
    bit_div = 8'd1; tx_frame_div = 8'd5; rx_frame_div = 8'd2;
    wait_cyc(17);
    tx_frame_div = 8'd3;               // R8 change again in the middle of a frame
    wait_cyc(300);
    cur_req = "R9";
    slave_sel = 1'b1;
    drive_ext(400, 3, 4);
    cur_req = "R10";
    bclk_inv = 1'b0;
    drive_ext(300, 2, 3);
    cur_req = "R11";
    bit_div = 8'd4; tx_frame_div = 8'd3; rx_frame_div = 8'd1;
    wait_cyc(5);
    slave_sel = 1'b0;
    wait_cyc(300);
    cur_req = "R1";
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(50);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule